// File: doc/BRIEF.md
# Prefetching Texture Cache Pipeline

This block is the tag-and-ordering front end of a texture cache. Each request is looked up and given a cache line when it arrives. It then joins an in-order fragment queue and waits there until its line holds the data. A tag hit is never answered on the spot. It waits behind every earlier request, so results leave in exactly the order the requests came in, even when the memory system returns fills out of order.

A miss allocates a slot in a reorder buffer and sends out a memory request tagged with that slot number. The memory side answers by presenting the slot number on the fill input. When the oldest fragment is a miss whose reorder-buffer slot has been filled, the line is marked present and a result is pushed into the output queue. The block stores only line presence and address. The data payload and the memory system lie outside it.

Top module: `tex_cache`

## Requirements
- R1: `req_stat_o` reports 0 when no request is offered, 1 for an accepted tag hit, 2 for an accepted miss and 3 for a rejection. A request is rejected when the fragment queue, the memory request queue or the reorder buffer is full, and a rejected request changes no state.
- R2: Lookup is direct-mapped. The set is block address bits [IDX_W-1:0], where block address = `req_addr_i >> OFF_W`. A miss claims its set's tag at once, so a second request to the same block in the next cycle reports 1.
- R3: Every accepted miss queues one memory request carrying the block address. Requests leave in acceptance order, and each is held stable on `mreq_baddr_o` until `mreq_ready_i` takes it.
- R4: Results leave the output queue in request acceptance order, whatever order the fills arrive in.
- R5: A miss result appears only after its fill has arrived. A hit result waits behind all earlier requests, and a hit found at the head of the fragment queue always has its line marked present.
- R6: A result carries the request id, the size field and the miss flag. A miss result also carries the value of a free-running cycle counter sampled when its fill arrived. The counter is 0 in the first cycle after reset. A hit result carries 0 in that field.
- R7: With RES_DEPTH results waiting, draining stops. It resumes on the next edge after a pop.
- R8: After reset every queue is empty, no line is present and `err_o` is low.
- R9: Reorder-buffer slot numbers on `mreq_rob_o` start at 0 and count up modulo ROB_DEPTH.
- R10: `err_o` rises if the head fragment is a miss that does not match the reorder-buffer head (id or line), or is a hit to a line not marked present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_addr_i | input | ADDR_W | Request byte address |
| req_id_i | input | ID_W | Request id, returned with the result |
| req_size_i | input | SIZE_W | Access size, returned with the result |
| req_stat_o | output | 2 | Request status, same cycle (R1) |
| mreq_valid_o | output | 1 | Memory request pending |
| mreq_ready_i | input | 1 | Memory side takes the request |
| mreq_baddr_o | output | ADDR_W-OFF_W | Block address to fetch |
| mreq_rob_o | output | clog2(ROB_DEPTH) | Reorder-buffer slot of the request |
| fill_valid_i | input | 1 | Fill returning |
| fill_rob_i | input | clog2(ROB_DEPTH) | Slot that the fill answers |
| res_valid_o | output | 1 | Result available |
| res_pop_i | input | 1 | Consume the result |
| res_id_o | output | ID_W | Result request id |
| res_size_o | output | SIZE_W | Result size field |
| res_miss_o | output | 1 | Result was a miss |
| res_time_o | output | TIME_W | Fill arrival cycle, 0 for hits |
| err_o | output | 1 | Ordering consistency error |

## Verification
The hardest case to reach is a hit that sits behind several outstanding misses while fills come back out of order and the output queue is full, all at once. Only then does a wrong ordering or an early release show up. The stimulus uses a small address pool so that hits and set conflicts are frequent. It picks a random outstanding slot for each fill, and it runs phases that starve fills, which fills the reorder buffer and causes rejections. Other phases stop popping results, which backs up the output queue.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TC_IDLE     = 2'd0,
    TC_HIT_RSV  = 2'd1,
    TC_MISS     = 2'd2,
    TC_RSV_FAIL = 2'd3
  } tc_stat_e;
endpackage

// File: rtl/tc_fifo.sv
module tc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] widx_o,
  output logic [PW-1:0] ridx_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= nxt(wp);
      if (pop_i)  rp <= nxt(rp);
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= wdata_i;
  end

  assign rdata_o = mem[rp];
  assign full_o  = (cnt == CW'(DEPTH));
  assign cnt_o   = cnt;
  assign widx_o  = wp;
  assign ridx_o  = rp;
endmodule

// File: rtl/tc_rob.sv
module tc_rob #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 2,
  parameter int ID_W   = 4,
  parameter int BA_W   = 14,
  parameter int TIME_W = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int EW    = LINE_W + ID_W + BA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [BA_W-1:0]   push_baddr_i,
  output logic [PW-1:0]     push_idx_o,
  output logic [CW-1:0]     cnt_o,
  output logic              full_o,
  input  logic              pop_i,
  input  logic              fill_i,
  input  logic [PW-1:0]     fill_idx_i,
  input  logic [TIME_W-1:0] now_i,
  output logic              h_ready_o,
  output logic [LINE_W-1:0] h_line_o,
  output logic [ID_W-1:0]   h_id_o,
  output logic [BA_W-1:0]   h_baddr_o,
  output logic [TIME_W-1:0] h_time_o
);
  logic [EW-1:0]     h_ent;
  logic [PW-1:0]     h_idx;
  logic              rdy [DEPTH];
  logic [TIME_W-1:0] tm  [DEPTH];

  tc_fifo #(.W(EW), .DEPTH(DEPTH)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .wdata_i ({push_line_i, push_id_i, push_baddr_i}),
    .pop_i   (pop_i),
    .rdata_o (h_ent),
    .full_o  (full_o),
    .cnt_o   (cnt_o),
    .widx_o  (push_idx_o),
    .ridx_o  (h_idx)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy[g] <= 1'b0;
      end else if (push_i && push_idx_o == PW'(g)) begin
        rdy[g] <= 1'b0;
      end else if (fill_i && fill_idx_i == PW'(g)) begin
        rdy[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk_i) begin
      if (fill_i && fill_idx_i == PW'(g)) tm[g] <= now_i;
    end
  end

  assign {h_line_o, h_id_o, h_baddr_o} = h_ent;
  assign h_ready_o = rdy[h_idx];
  assign h_time_o  = tm[h_idx];
endmodule

// File: rtl/tc_lines.sv
module tc_lines #(
  parameter int N_LINES = 4,
  parameter int TAG_W   = 12,
  parameter int BA_W    = 14,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             alloc_i,
  input  logic             dfill_i,
  input  logic [IDX_W-1:0] dfill_idx_i,
  input  logic [BA_W-1:0]  dfill_baddr_i,
  input  logic [IDX_W-1:0] dq_idx_i,
  output logic             dq_valid_o
);
  // tag side updates at request time, data side at drain time
  logic             tv [N_LINES];
  logic [TAG_W-1:0] tt [N_LINES];
  logic             dv [N_LINES];
  logic [BA_W-1:0]  db [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tv[g] <= 1'b0;
        dv[g] <= 1'b0;
      end else begin
        if (alloc_i && lk_idx_i == IDX_W'(g))    tv[g] <= 1'b1;
        if (dfill_i && dfill_idx_i == IDX_W'(g)) dv[g] <= 1'b1;
      end
    end
    always_ff @(posedge clk_i) begin
      if (alloc_i && lk_idx_i == IDX_W'(g))    tt[g] <= lk_tag_i;
      if (dfill_i && dfill_idx_i == IDX_W'(g)) db[g] <= dfill_baddr_i;
    end
  end

  logic [BA_W-1:0] db_unused;
  assign db_unused  = db[dq_idx_i];
  assign lk_hit_o   = tv[lk_idx_i] && (tt[lk_idx_i] == lk_tag_i);
  assign dq_valid_o = dv[dq_idx_i];
endmodule

// File: rtl/tex_cache.sv
module tex_cache
  import tc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 4,
  parameter int N_LINES    = 4,
  parameter int ID_W       = 4,
  parameter int SIZE_W     = 2,
  parameter int FRAG_DEPTH = 8,
  parameter int REQ_DEPTH  = 4,
  parameter int ROB_DEPTH  = 4,
  parameter int RES_DEPTH  = 2,
  parameter int TIME_W     = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_valid_i,
  input  logic [ADDR_W-1:0]                     req_addr_i,
  input  logic [ID_W-1:0]                       req_id_i,
  input  logic [SIZE_W-1:0]                     req_size_i,
  output logic [1:0]                            req_stat_o,
  output logic                                  mreq_valid_o,
  input  logic                                  mreq_ready_i,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  mreq_baddr_o,
  output logic [$clog2(ROB_DEPTH)-1:0]          mreq_rob_o,
  input  logic                                  fill_valid_i,
  input  logic [$clog2(ROB_DEPTH)-1:0]          fill_rob_i,
  output logic                                  res_valid_o,
  input  logic                                  res_pop_i,
  output logic [ID_W-1:0]                       res_id_o,
  output logic [SIZE_W-1:0]                     res_size_o,
  output logic                                  res_miss_o,
  output logic [TIME_W-1:0]                     res_time_o,
  output logic                                  err_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(N_LINES);
  localparam int BA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = BA_W - IDX_W;
  localparam int ROB_W  = $clog2(ROB_DEPTH);
  localparam int FRAG_W = ID_W + IDX_W + 1 + SIZE_W;
  localparam int RQ_W   = BA_W + ROB_W;
  localparam int RES_W  = ID_W + SIZE_W + 1 + TIME_W;
  localparam int FC_W   = $clog2(FRAG_DEPTH + 1);
  localparam int QC_W   = $clog2(REQ_DEPTH + 1);
  localparam int RC_W   = $clog2(ROB_DEPTH + 1);
  localparam int SC_W   = $clog2(RES_DEPTH + 1);

  logic [OFF_W-1:0] off_unused;
  logic [BA_W-1:0]  req_baddr;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign off_unused = req_addr_i[OFF_W-1:0];
  assign req_baddr  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_idx    = req_baddr[IDX_W-1:0];
  assign req_tag    = req_baddr[BA_W-1:IDX_W];

  logic [TIME_W-1:0] now_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  // fragment queue
  logic [FRAG_W-1:0] frag_rdata;
  logic [FC_W-1:0]   frag_cnt;
  logic              frag_full, frag_nonempty, drain;
  logic [$clog2(FRAG_DEPTH)-1:0] frag_widx_unused, frag_ridx_unused;
  logic [ID_W-1:0]   f_id;
  logic [IDX_W-1:0]  f_line;
  logic              f_miss;
  logic [SIZE_W-1:0] f_size;

  // memory request queue
  logic [RQ_W-1:0]  rq_rdata;
  logic [QC_W-1:0]  rq_cnt;
  logic             rq_full, rq_pop;
  logic [$clog2(REQ_DEPTH)-1:0] rq_widx_unused, rq_ridx_unused;

  // reorder buffer
  logic [ROB_W-1:0]  rob_idx;
  logic [RC_W-1:0]   rob_cnt;
  logic              rob_full, rob_pop, rob_h_ready;
  logic [IDX_W-1:0]  rob_h_line;
  logic [ID_W-1:0]   rob_h_id;
  logic [BA_W-1:0]   rob_h_baddr;
  logic [TIME_W-1:0] rob_h_time;

  // result queue
  logic [RES_W-1:0] res_rdata;
  logic [SC_W-1:0]  res_cnt;
  logic             res_full, res_pop;
  logic [$clog2(RES_DEPTH)-1:0] res_widx_unused, res_ridx_unused;

  logic     lk_hit, blocked, acc, acc_miss, dq_valid, drain_ok, head_mismatch;
  tc_stat_e stat;

  assign blocked  = frag_full || rq_full || rob_full;
  assign acc      = req_valid_i && !blocked;
  assign acc_miss = acc && !lk_hit;

  always_comb begin
    if (!req_valid_i)  stat = TC_IDLE;
    else if (blocked)  stat = TC_RSV_FAIL;
    else if (lk_hit)   stat = TC_HIT_RSV;
    else               stat = TC_MISS;
  end
  assign req_stat_o = stat;

  tc_lines #(.N_LINES(N_LINES), .TAG_W(TAG_W), .BA_W(BA_W)) u_lines (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lk_idx_i      (req_idx),
    .lk_tag_i      (req_tag),
    .lk_hit_o      (lk_hit),
    .alloc_i       (acc_miss),
    .dfill_i       (rob_pop),
    .dfill_idx_i   (f_line),
    .dfill_baddr_i (rob_h_baddr),
    .dq_idx_i      (f_line),
    .dq_valid_o    (dq_valid)
  );

  tc_fifo #(.W(FRAG_W), .DEPTH(FRAG_DEPTH)) u_frag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc),
    .wdata_i ({req_id_i, req_idx, !lk_hit, req_size_i}),
    .pop_i   (drain),
    .rdata_o (frag_rdata),
    .full_o  (frag_full),
    .cnt_o   (frag_cnt),
    .widx_o  (frag_widx_unused),
    .ridx_o  (frag_ridx_unused)
  );
  assign {f_id, f_line, f_miss, f_size} = frag_rdata;
  assign frag_nonempty = (frag_cnt != '0);

  tc_fifo #(.W(RQ_W), .DEPTH(REQ_DEPTH)) u_rq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (acc_miss),
    .wdata_i ({req_baddr, rob_idx}),
    .pop_i   (rq_pop),
    .rdata_o (rq_rdata),
    .full_o  (rq_full),
    .cnt_o   (rq_cnt),
    .widx_o  (rq_widx_unused),
    .ridx_o  (rq_ridx_unused)
  );
  assign mreq_valid_o = (rq_cnt != '0);
  assign rq_pop       = mreq_valid_o && mreq_ready_i;
  assign {mreq_baddr_o, mreq_rob_o} = rq_rdata;

  tc_rob #(
    .DEPTH(ROB_DEPTH), .LINE_W(IDX_W), .ID_W(ID_W), .BA_W(BA_W), .TIME_W(TIME_W)
  ) u_rob (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (acc_miss),
    .push_line_i  (req_idx),
    .push_id_i    (req_id_i),
    .push_baddr_i (req_baddr),
    .push_idx_o   (rob_idx),
    .cnt_o        (rob_cnt),
    .full_o       (rob_full),
    .pop_i        (rob_pop),
    .fill_i       (fill_valid_i),
    .fill_idx_i   (fill_rob_i),
    .now_i        (now_q),
    .h_ready_o    (rob_h_ready),
    .h_line_o     (rob_h_line),
    .h_id_o       (rob_h_id),
    .h_baddr_o    (rob_h_baddr),
    .h_time_o     (rob_h_time)
  );

  // drain head fragment in order; misses wait on the reorder-buffer head
  assign drain_ok = frag_nonempty && !res_full;
  assign drain    = drain_ok && (!f_miss || ((rob_cnt != '0) && rob_h_ready));
  assign rob_pop  = drain && f_miss;

  assign head_mismatch = f_miss
    ? ((rob_cnt == '0) || (rob_h_id != f_id) || (rob_h_line != f_line))
    : !dq_valid;
  assign err_o = frag_nonempty && head_mismatch;

  tc_fifo #(.W(RES_W), .DEPTH(RES_DEPTH)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (drain),
    .wdata_i ({f_id, f_size, f_miss, (f_miss ? rob_h_time : TIME_W'(0))}),
    .pop_i   (res_pop),
    .rdata_o (res_rdata),
    .full_o  (res_full),
    .cnt_o   (res_cnt),
    .widx_o  (res_widx_unused),
    .ridx_o  (res_ridx_unused)
  );
  assign res_valid_o = (res_cnt != '0);
  assign res_pop     = res_valid_o && res_pop_i;
  assign {res_id_o, res_size_o, res_miss_o, res_time_o} = res_rdata;
endmodule

// File: rtl/tex_cache_chk.sv
module tex_cache_chk #(
  parameter int FRAG_DEPTH = 8,
  parameter int ROB_DEPTH  = 4,
  parameter int RES_DEPTH  = 2,
  parameter int BA_W       = 14
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [1:0]                      req_stat_i,
  input logic [$clog2(FRAG_DEPTH+1)-1:0] frag_cnt_i,
  input logic                            drain_i,
  input logic [$clog2(ROB_DEPTH+1)-1:0]  rob_cnt_i,
  input logic                            rob_pop_i,
  input logic                            hit_drain_i,
  input logic                            line_valid_i,
  input logic [$clog2(RES_DEPTH+1)-1:0]  res_cnt_i,
  input logic                            res_pop_i,
  input logic                            err_i,
  input logic                            mreq_valid_i,
  input logic                            mreq_ready_i,
  input logic [BA_W-1:0]                 mreq_baddr_i
);
  AST_FAIL_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_stat_i == 2'd3 && !drain_i) |=> frag_cnt_i == $past(frag_cnt_i)); // R1

  AST_MISS_TAKES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_stat_i == 2'd2 && !rob_pop_i) |=> rob_cnt_i == $past(rob_cnt_i) + 1'b1); // R3

  AST_MREQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_i && !mreq_ready_i) |=> (mreq_valid_i && $stable(mreq_baddr_i))); // R3

  AST_HIT_LINE_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_drain_i |-> line_valid_i); // R5

  AST_RES_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_cnt_i == ($clog2(RES_DEPTH+1))'(RES_DEPTH) && !res_pop_i) |=> $stable(res_cnt_i)); // R7

  AST_NO_ORDER_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_i); // R10
endmodule

bind tex_cache tex_cache_chk #(
  .FRAG_DEPTH(FRAG_DEPTH), .ROB_DEPTH(ROB_DEPTH), .RES_DEPTH(RES_DEPTH), .BA_W(BA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_stat_i   (req_stat_o),
  .frag_cnt_i   (frag_cnt),
  .drain_i      (drain),
  .rob_cnt_i    (rob_cnt),
  .rob_pop_i    (rob_pop),
  .hit_drain_i  (drain && !f_miss),
  .line_valid_i (dq_valid),
  .res_cnt_i    (res_cnt),
  .res_pop_i    (res_pop),
  .err_i        (err_o),
  .mreq_valid_i (mreq_valid_o),
  .mreq_ready_i (mreq_ready_i),
  .mreq_baddr_i (mreq_baddr_o)
);

// File: tb/tex_cache_tb.sv
`timescale 1ns/1ps
module tex_cache_tb;
  localparam int ADDR_W = 16, LINE_BYTES = 4, N_LINES = 4, ID_W = 4, SIZE_W = 2;
  localparam int FRAG_DEPTH = 8, REQ_DEPTH = 4, ROB_DEPTH = 4, RES_DEPTH = 2, TIME_W = 16;
  localparam int OFF_W = 2, BA_W = ADDR_W - OFF_W, ROB_W = 2;

  logic clk, rst_n;
  logic req_valid, mreq_ready, fill_valid, res_pop;
  logic [ADDR_W-1:0] req_addr;
  logic [ID_W-1:0]   req_id;
  logic [SIZE_W-1:0] req_size;
  logic [1:0]        req_stat;
  logic              mreq_valid, res_valid, res_miss, err;
  logic [BA_W-1:0]   mreq_baddr;
  logic [ROB_W-1:0]  mreq_rob, fill_rob;
  logic [ID_W-1:0]   res_id;
  logic [SIZE_W-1:0] res_size;
  logic [TIME_W-1:0] res_time;

  tex_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_id_i(req_id), .req_size_i(req_size),
    .req_stat_o(req_stat),
    .mreq_valid_o(mreq_valid), .mreq_ready_i(mreq_ready), .mreq_baddr_o(mreq_baddr), .mreq_rob_o(mreq_rob),
    .fill_valid_i(fill_valid), .fill_rob_i(fill_rob),
    .res_valid_o(res_valid), .res_pop_i(res_pop), .res_id_o(res_id), .res_size_o(res_size),
    .res_miss_o(res_miss), .res_time_o(res_time), .err_o(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;

  typedef struct { int id; int line; bit miss; int size; } frag_t;
  typedef struct { int baddr; int rob; } mq_t;
  typedef struct { int id; int size; bit miss; int tm; } res_t;
  frag_t fq[$];
  mq_t   mq[$];
  res_t  sq[$];
  int    pend[$];
  bit    tv[N_LINES];
  int    tt[N_LINES];
  bit    rrdy[ROB_DEPTH];
  int    rtime[ROB_DEPTH];
  int    rh = 0, rt = 0, rc = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_blocked();
    return fq.size() >= FRAG_DEPTH || mq.size() >= REQ_DEPTH || rc >= ROB_DEPTH;
  endfunction

  function automatic bit m_hit();
    int ba = int'(req_addr) >> OFF_W;
    return tv[ba % N_LINES] && tt[ba % N_LINES] == ba / N_LINES;
  endfunction

  function automatic int exp_stat();
    if (!req_valid) return 0;
    if (m_blocked()) return 3;
    return m_hit() ? 1 : 2;
  endfunction

  task automatic compare();
    int es = exp_stat();
    chk(int'(req_stat) == es, (es == 1 || es == 2) ? "R2" : "R1", "req_stat", int'(req_stat), es);
    chk(mreq_valid == (mq.size() > 0), "R3", "mreq_valid", int'(mreq_valid), int'(mq.size() > 0));
    if (mq.size() > 0) begin
      chk(int'(mreq_baddr) == mq[0].baddr, "R3", "mreq_baddr", int'(mreq_baddr), mq[0].baddr);
      chk(int'(mreq_rob) == mq[0].rob, "R9", "mreq_rob", int'(mreq_rob), mq[0].rob);
    end
    chk(res_valid == (sq.size() > 0), (sq.size() == RES_DEPTH) ? "R7" : "R5", "res_valid",
        int'(res_valid), int'(sq.size() > 0));
    if (sq.size() > 0) begin
      chk(int'(res_id) == sq[0].id, "R4", "res_id", int'(res_id), sq[0].id);
      chk(int'(res_size) == sq[0].size, "R6", "res_size", int'(res_size), sq[0].size);
      chk(res_miss == sq[0].miss, "R6", "res_miss", int'(res_miss), int'(sq[0].miss));
      chk(int'(res_time) == sq[0].tm, "R6", "res_time", int'(res_time), sq[0].tm);
    end
    chk(err == 1'b0, "R10", "err", int'(err), 0);
  endtask

  task automatic update();
    int ba = int'(req_addr) >> OFF_W;
    int idx = ba % N_LINES;
    bit acc = req_valid && !m_blocked();
    bit hit = m_hit();
    bit d = 0;
    bit mpop = mreq_ready && mq.size() > 0;
    bit spop = res_pop && sq.size() > 0;
    if (fq.size() > 0 && sq.size() < RES_DEPTH)
      d = !fq[0].miss || (rc > 0 && rrdy[rh]);
    if (spop) void'(sq.pop_front());
    if (d) begin
      frag_t h = fq.pop_front();
      if (h.miss) begin
        sq.push_back('{h.id, h.size, 1'b1, rtime[rh]});
        rh = (rh + 1) % ROB_DEPTH;
        rc--;
      end else begin
        sq.push_back('{h.id, h.size, 1'b0, 0});
      end
    end
    if (mpop) begin
      mq_t m = mq.pop_front();
      pend.push_back(m.rob);
    end
    if (fill_valid) begin
      rrdy[fill_rob] = 1'b1;
      rtime[fill_rob] = cyc;
    end
    if (acc) begin
      fq.push_back('{int'(req_id), idx, !hit, int'(req_size)});
      if (!hit) begin
        mq.push_back('{ba, rt});
        rrdy[rt] = 1'b0;
        rt = (rt + 1) % ROB_DEPTH;
        rc++;
        tv[idx] = 1'b1;
        tt[idx] = ba / N_LINES;
      end
    end
    cyc++;
  endtask

  // one cycle: called at a negedge, returns at the next negedge
  task automatic cycle(input bit rv, input int addr, input bit mr, input bit dofill, input bit pop);
    req_valid  = rv;
    req_addr   = ADDR_W'(addr);
    req_id     = ID_W'(cyc);
    req_size   = SIZE_W'($urandom_range(3));
    mreq_ready = mr;
    res_pop    = pop;
    fill_valid = 1'b0;
    fill_rob   = '0;
    if (dofill && pend.size() > 0) begin
      int k = $urandom_range(pend.size() - 1);
      fill_valid = 1'b1;
      fill_rob   = ROB_W'(pend[k]);
      pend.delete(k);
    end
    #1;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  function automatic int rand_addr();
    int tg = $urandom_range(2);
    int ix = $urandom_range(N_LINES - 1);
    return ((tg * N_LINES + ix) << OFF_W) | $urandom_range(3);
  endfunction

  task automatic phase(input int n, input int preq, input int pfill, input int pmr, input int ppop);
    for (int i = 0; i < n; i++)
      cycle($urandom_range(99) < preq, rand_addr(), $urandom_range(99) < pmr,
            $urandom_range(99) < pfill, $urandom_range(99) < ppop);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R4 act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_id = '0; req_size = '0;
    mreq_ready = 0; fill_valid = 0; fill_rob = '0; res_pop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(req_stat == 2'd0, "R8", "req_stat", int'(req_stat), 0);
    chk(!mreq_valid, "R8", "mreq_valid", int'(mreq_valid), 0);
    chk(!res_valid, "R8", "res_valid", int'(res_valid), 0);
    chk(!err, "R8", "err", int'(err), 0);
    rst_n = 1'b1;
    // R2/R5: miss, then same block hit-reserved, held behind the miss until fill
    cycle(1, 'h40, 1, 0, 1);
    cycle(1, 'h41, 1, 0, 1);
    for (int i = 0; i < 5; i++) cycle(0, 0, 1, 0, 1);
    cycle(0, 0, 1, 1, 1);
    for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0, 1);
    phase(500, 60, 50, 80, 80);   // mixed traffic, out-of-order fills
    phase(400, 90, 5, 90, 90);    // fill starvation: reorder buffer full, rejections (R1)
    phase(400, 70, 60, 100, 5);   // result queue backed up (R7)
    phase(300, 0, 100, 100, 100); // drain everything
    chk(fq.size() == 0 && !res_valid, "R4", "drained", int'(res_valid), 0);
    summary();
    $finish;
  end
endmodule